// File: doc/BRIEF.md
# DMA Page Register Address Composer

This block sits beside a pair of cascaded four-channel DMA controllers and supplies the upper address bits that the controllers cannot produce. It holds one page byte for each of the seven memory-capable channels and one for memory refresh. It merges the selected page with the 16-bit address word from the active controller into a 24-bit system address and a byte-high-enable strobe. Software loads and reads the page bytes through a small 8-bit I/O port.

Channels 0 to 3 move bytes. Their page sits directly above the controller word, and byte-high-enable follows the inverse of A0. Channels 5 to 7 move 16-bit words. Their controller word is shifted up by one bit, so only the top seven bits of their page byte are used, and A0 and byte-high-enable are held low. Channel 4 only links the two controllers, so it has no page byte and never drives an address. The controller word is never added to the page, so it wraps inside its own window of 64KB or 128KB. The result is purely combinational from the inputs and the stored pages, so it follows the channel selection in the same cycle.

Top module: `dma_page_composer`

## Requirements
- R1: After reset every page byte reads back as 0x00.
- R2: A write with `ioWr` high at a clock edge stores `ioWrData` in the page byte decoded from `ioAddr`. The port map is: 0x87 channel 0, 0x83 channel 1, 0x81 channel 2, 0x82 channel 3, 0x8B channel 5, 0x89 channel 6, 0x8A channel 7, 0x8F refresh. While `ioRd` is high on a decoded port, `ioRdData` returns that stored byte in the same cycle.
- R3: A write to any other port changes no page byte. `ioRdData` is 0x00 whenever `ioRd` is low or the port is not decoded.
- R4: With `chanValid` high, `refreshCycle` low and `chanSel` 0 to 3, `sysAddr[23:16]` is that channel's page byte and `sysAddr[15:0]` is `ctlWord`.
- R5: In the case of R4, `bhe` equals the inverse of `sysAddr[0]`.
- R6: With `chanValid` high, `refreshCycle` low and `chanSel` 5 to 7, `sysAddr[23:17]` is bits 7..1 of the channel's page byte and `sysAddr[16:1]` is `ctlWord`. `sysAddr[0]` and `bhe` are 0, and page bit 0 has no effect.
- R7: The controller word never carries into the page bits. With `ctlWord` = 0xFFFF, the page field still equals the stored page.
- R8: With `refreshCycle` high, `sysAddr` is {refresh page, `ctlWord`} and `bhe` is the inverse of A0, whatever `chanValid` and `chanSel` hold.
- R9: With `refreshCycle` low and either `chanValid` low or `chanSel` = 4, `sysAddr` is 0 and `bhe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioAddr | input | 8 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioRdData | output | 8 | Page readback data |
| chanValid | input | 1 | A DMA channel is active |
| chanSel | input | 3 | Active channel number 0..7 |
| ctlWord | input | 16 | Address word from the DMA controller |
| refreshCycle | input | 1 | Memory refresh cycle in progress |
| sysAddr | output | 24 | Composed system address A23..A0 |
| bhe | output | 1 | Byte high enable, active high |

## Verification
The bench writes a different page byte to every port. Some of these bytes have bit 0 set, so it is visible whether a word channel ignores that bit. It then writes to all 248 undecoded ports and reads all 256 ports back, which separates a correct decode from an aliased or missing one. The composition is swept over every channel, with refresh on and off and valid on and off, against controller words 0x0000, 0xFFFF, 0x0001, 0x8000, 0xA5A5 and 0x5A5A. The all-ones and top-bit words expose any carry into the page. The odd and even words separate the byte-high-enable rule of byte channels from the forced-low rule of word channels.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int PAGE_W = 8;
  localparam int WORD_W = 16;
  localparam int SLOT_N = 8;
  localparam int IDX_W  = $clog2(SLOT_N);
  localparam int ADDR_W = PAGE_W + WORD_W;
  // Slot 4 has no channel (cascade link), so it holds the refresh page.
  localparam logic [IDX_W-1:0] REFRESH_SLOT = 3'd4;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_BYTE,
    MODE_WORD,
    MODE_REFRESH
  } addrMode_e;

  typedef struct packed {
    logic [SLOT_N-1:0] wrStrobe;
    logic              rdHit;
    logic [IDX_W-1:0]  rdIdx;
    addrMode_e         mode;
    logic [IDX_W-1:0]  pageIdx;
  } pageCtl_t;

  // Returns {hit, slot} for an I/O port number.
  function automatic logic [IDX_W:0] decodePort(input logic [7:0] port);
    logic [IDX_W:0] res;
    unique case (port)
      8'h87:   res = {1'b1, 3'd0};
      8'h83:   res = {1'b1, 3'd1};
      8'h81:   res = {1'b1, 3'd2};
      8'h82:   res = {1'b1, 3'd3};
      8'h8F:   res = {1'b1, REFRESH_SLOT};
      8'h8B:   res = {1'b1, 3'd5};
      8'h89:   res = {1'b1, 3'd6};
      8'h8A:   res = {1'b1, 3'd7};
      default: res = '0;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/dma_page_ctrl.sv
module dma_page_ctrl
  import dma_page_pkg::*;
#(
  parameter int CHAN_W = IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              chanValid,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              refreshCycle,
  output pageCtl_t          ctl
);
  localparam logic [CHAN_W-1:0] CASCADE_CH = CHAN_W'(REFRESH_SLOT);
  localparam logic [CHAN_W-1:0] FIRST_WORD_CH = CHAN_W'(SLOT_N / 2);

  logic [IDX_W:0] portHit;
  logic           hit;
  logic [IDX_W-1:0] slot;

  assign portHit = decodePort(ioAddr);
  assign hit     = portHit[IDX_W];
  assign slot    = portHit[IDX_W-1:0];

  always_comb begin
    ctl = '0;
    for (int i = 0; i < SLOT_N; i++) begin
      ctl.wrStrobe[i] = ioWr && hit && (slot == IDX_W'(i));
    end
    ctl.rdHit = ioRd && hit;
    ctl.rdIdx = slot;
    if (refreshCycle) begin
      ctl.mode    = MODE_REFRESH;
      ctl.pageIdx = REFRESH_SLOT;
    end else if (!chanValid || chanSel == CASCADE_CH) begin
      ctl.mode    = MODE_IDLE;
      ctl.pageIdx = '0;
    end else if (chanSel < FIRST_WORD_CH) begin
      ctl.mode    = MODE_BYTE;
      ctl.pageIdx = IDX_W'(chanSel);
    end else begin
      ctl.mode    = MODE_WORD;
      ctl.pageIdx = IDX_W'(chanSel);
    end
  end

  // R2/R3: at most one page byte is written per edge
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.wrStrobe));
  // R3: no write strobe without the write input
  p_no_spurious_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ioWr |-> ctl.wrStrobe == '0);
  // R8: a refresh cycle always selects the refresh page
  p_refresh_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    refreshCycle |-> (ctl.mode == MODE_REFRESH && ctl.pageIdx == REFRESH_SLOT));
endmodule

// File: rtl/dma_page_datapath.sv
module dma_page_datapath
  import dma_page_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pageCtl_t          ctl,
  input  logic [PAGE_W-1:0] ioWrData,
  input  logic [WORD_W-1:0] ctlWord,
  output logic [PAGE_W-1:0] ioRdData,
  output logic [ADDR_W-1:0] sysAddr,
  output logic              bhe
);
  logic [PAGE_W-1:0] pageReg [SLOT_N];
  logic [PAGE_W-1:0] selPage;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pageReg[s] <= '0;
      else if (ctl.wrStrobe[s]) pageReg[s] <= ioWrData;
    end

    // R2: a strobed write lands in its slot
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
      ctl.wrStrobe[s] |=> pageReg[s] == $past(ioWrData));
    // R3: a slot without a strobe holds its value
    p_slot_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.wrStrobe[s] |=> $stable(pageReg[s]));
  end

  assign ioRdData = ctl.rdHit ? pageReg[ctl.rdIdx] : '0;
  assign selPage  = pageReg[ctl.pageIdx];

  always_comb begin
    sysAddr = '0;
    bhe     = 1'b0;
    unique case (ctl.mode)
      MODE_BYTE, MODE_REFRESH: begin
        sysAddr = {selPage, ctlWord};
        bhe     = ~ctlWord[0];
      end
      MODE_WORD: begin
        sysAddr = {selPage[PAGE_W-1:1], ctlWord, 1'b0};
        bhe     = 1'b0;
      end
      default: begin
        sysAddr = '0;
        bhe     = 1'b0;
      end
    endcase
  end

  // R6: word transfers never start on an odd byte
  p_word_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mode == MODE_WORD |-> (!sysAddr[0] && !bhe));
  // R9: idle drives a zero address
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mode == MODE_IDLE |-> (sysAddr == '0 && !bhe));
  // R7: the page field is the stored page whatever the word
  p_no_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mode == MODE_BYTE |-> sysAddr[ADDR_W-1:WORD_W] == selPage);
endmodule

// File: rtl/dma_page_composer.sv
module dma_page_composer
  import dma_page_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         ioAddr,
  input  logic [PAGE_W-1:0]  ioWrData,
  input  logic               ioWr,
  input  logic               ioRd,
  output logic [PAGE_W-1:0]  ioRdData,
  input  logic               chanValid,
  input  logic [IDX_W-1:0]   chanSel,
  input  logic [WORD_W-1:0]  ctlWord,
  input  logic               refreshCycle,
  output logic [ADDR_W-1:0]  sysAddr,
  output logic               bhe
);
  pageCtl_t ctl;

  dma_page_ctrl #(.CHAN_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .chanValid(chanValid), .chanSel(chanSel), .refreshCycle(refreshCycle),
    .ctl(ctl)
  );

  dma_page_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ioWrData(ioWrData),
    .ctlWord(ctlWord), .ioRdData(ioRdData), .sysAddr(sysAddr), .bhe(bhe)
  );

  // R5/R8: byte-form cycles drive bhe as the inverse of A0
  p_byte_bhe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCycle || (chanValid && chanSel < 3'd4)) |-> bhe == ~sysAddr[0]);
  // R3: no readback without a read strobe
  p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdData == '0);
endmodule

// File: tb/dma_page_composer_tb_top.sv
module dma_page_composer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ioAddr = '0, ioWrData = '0, ioRdData;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic        chanValid = 1'b0, refreshCycle = 1'b0, bhe;
  logic [2:0]  chanSel = '0;
  logic [15:0] ctlWord = '0;
  logic [23:0] sysAddr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expPage [8];

  always #2 clk = ~clk;

  dma_page_composer dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(ioRdData), .chanValid(chanValid), .chanSel(chanSel),
    .ctlWord(ctlWord), .refreshCycle(refreshCycle), .sysAddr(sysAddr), .bhe(bhe)
  );

  // Port map from R2: returns slot, or -1 when undecoded
  function automatic int portSlot(input int p);
    case (p)
      'h87: return 0;  'h83: return 1;  'h81: return 2;  'h82: return 3;
      'h8F: return 4;  'h8B: return 5;  'h89: return 6;  'h8A: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = 8'(a); ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioReadCheck(input string req, input int a);
    int s;
    s = portSlot(a);
    ioAddr = 8'(a); ioRd = 1'b1;
    #1;
    check(req, 32'(ioRdData), (s < 0) ? 32'd0 : 32'(expPage[s]));
    ioRd = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] words [6];
    logic [23:0] expA;
    logic        expB;
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'h0001;
    words[3] = 16'h8000; words[4] = 16'hA5A5; words[5] = 16'h5A5A;
    for (int i = 0; i < 8; i++) expPage[i] = 8'h00;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: every page reads zero after reset; R3: quiet when not reading
    for (int p = 'h80; p < 'h90; p++) ioReadCheck("R1", p);
    #1; check("R3", 32'(ioRdData), 32'd0);
    check("R9", {7'd0, bhe, sysAddr}, 32'd0);

    // R2: distinct pages, some with bit 0 set
    for (int p = 0; p < 256; p++) begin
      int s;
      s = portSlot(p);
      if (s >= 0) begin
        expPage[s] = 8'(8'h11 * (s + 1) + s % 2);
        ioWrite(p, expPage[s]);
      end
    end
    for (int p = 'h80; p < 'h90; p++) ioReadCheck("R2", p);

    // R3: writes to every undecoded port change nothing
    for (int p = 0; p < 256; p++)
      if (portSlot(p) < 0) ioWrite(p, 8'hEE);
    @(negedge clk);
    for (int p = 0; p < 256; p++) ioReadCheck("R3", p);

    // R4..R9: composition sweep
    for (int rf = 0; rf < 2; rf++)
      for (int v = 0; v < 2; v++)
        for (int c = 0; c < 8; c++)
          for (int w = 0; w < 6; w++) begin
            string req;
            @(negedge clk);
            refreshCycle = rf[0]; chanValid = v[0]; chanSel = 3'(c); ctlWord = words[w];
            #1;
            if (rf == 1) begin
              expA = 24'(expPage[4]) * 24'h10000 + 24'(words[w]);
              expB = ~words[w][0];
              req = "R8";
            end else if (v == 0 || c == 4) begin
              expA = '0; expB = 1'b0; req = "R9";
            end else if (c < 4) begin
              expA = 24'(expPage[c]) * 24'h10000 + 24'(words[w]);
              expB = ~words[w][0];
              req = (w == 1) ? "R7" : "R4";
            end else begin
              expA = 24'(expPage[c] / 2) * 24'h20000 + 24'(words[w]) * 24'd2;
              expB = 1'b0;
              req = (w == 1) ? "R7" : "R6";
            end
            check(req, 32'(sysAddr), 32'(expA));
            check((c < 4 && rf == 0 && v == 1) ? "R5" : req, 32'(bhe), 32'(expB));
          end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule